// File: doc/BRIEF.md
# SPI Register Responder with Delayed Reply and CRC

This block is the target side of a serial register link. A host frames each transaction with an active-low chip select. It shifts in a command byte, then a data byte, and in CRC mode a third check byte. The command byte carries a direction flag and a 7-bit register address. The block turns each accepted write into a one-cycle strobe on a plain register bus. For a read, it samples the register value when the frame closes.

The reply is deferred by one transaction. While the host shifts the next frame in, the block shifts out the command byte of the last accepted frame and that frame's data. The data is the written byte for a write and the fetched register value for a read. In CRC mode a check byte over the two reply bytes follows. Two fixed patterns replace the reply in special cases. One marks a frame rejected on a bad check byte. The other marks a frame that arrived while the local clock was not yet usable. In both cases the host has to repeat the frame.

The serial pins are sampled by the system clock through a synchronizer, so SCLK must be several times slower than `clk`. The register bus has no handshake: `reg_rdata` is a combinational function of `reg_addr` supplied by the register file, and writes are always accepted.

Top module: `spi_reg_responder`

## Requirements
- R1: SPI mode 0 with the most significant bit first. MOSI is sampled on SCLK rising edges and MISO changes after falling edges. The first byte is {dir, addr[6:0]} with dir=1 for a write, and the second byte is the data, which a read ignores.
- R2: When `crc_en` is high at the chip-select fall, the frame is 24 bits long. Its third byte must equal CRC-8 over the first two bytes, using polynomial 0x07, initial value 0x00 and MSB first. With `crc_en` low the frame is 16 bits long.
- R3: An accepted write drives `reg_wr_en` for exactly one clock, after chip select rises. During that clock `reg_addr` and `reg_wdata` carry the frame's address and data.
- R4: While selected, MISO sends the command byte of the last accepted frame, then its data byte (the write data, or for a read the `reg_rdata` seen at frame end). In CRC mode it then sends CRC-8 over those two bytes.
- R5: A CRC-mode frame with a wrong check byte causes no write. The next frame's MISO is 0xFFFFAA (16-bit frames see 0xFFFF).
- R6: If `clk_ready` is low at the chip-select fall, MISO is all ones for the whole frame. The frame causes no write and leaves the stored reply unchanged.
- R7: A frame whose bit count differs from the length that R2 selects is ignored. It causes no write and leaves the stored reply unchanged.
- R8: A read frame never writes, and the register it addresses keeps its value.
- R9: After reset, MISO is low while chip select is high and the stored reply is all zeros (command 0x00, data 0x00, CRC 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial reply to the host, low when not selected |
| crc_en | input | 1 | Selects 24-bit frames with a check byte |
| clk_ready | input | 1 | High when the local clock is usable |
| reg_addr | output | 7 | Register address of the current frame |
| reg_wdata | output | 8 | Write data of the current frame |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
The stored reply, its error flag and the bit counter can only be observed one frame late. Any corruption of them shows on MISO during the frame that follows the faulty one, so the bench compares every bit of every reply and also checks the write count after each frame. A dropped or spurious write surfaces in the strobe count at once. It also surfaces on MISO no later than the next read of that address, which the directed sequence issues right after each rejected or ignored frame.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = BYTE_W - 1;
  localparam int unsigned FRAME_MAX = 3 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  // one CRC update, MSB-first serial form
  function automatic byte_t crc_step(byte_t c, logic b, byte_t poly);
    byte_t n;
    n = {c[BYTE_W-2:0], 1'b0};
    if (c[BYTE_W-1] ^ b) n = n ^ poly;
    return n;
  endfunction

  // CRC over a two-byte word, zero initial value
  function automatic byte_t crc_word(logic [2*BYTE_W-1:0] w, byte_t poly);
    byte_t c;
    c = '0;
    for (int i = 2*BYTE_W-1; i >= 0; i--) c = crc_step(c, w[i], poly);
    return c;
  endfunction
endpackage

// File: rtl/spi_rsp_sync.sv
module spi_rsp_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rsp_crc.sv
module spi_rsp_crc
  import spi_rsp_pkg::*;
#(
  parameter byte_t POLY = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  input  logic  din,
  output byte_t crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (step)  crc <= crc_step(crc, din, POLY);
  end
endmodule

// File: rtl/spi_rsp_txsh.sv
module spi_rsp_txsh #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign msb = sh[W-1];
endmodule

// File: rtl/spi_reg_responder.sv
module spi_reg_responder
  import spi_rsp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter byte_t       CRC_POLY    = 8'h07,
  parameter byte_t       ERR_TAIL    = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              crc_en,
  input  logic              clk_ready,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int unsigned W2    = 2 * BYTE_W;
  localparam int unsigned FW    = FRAME_MAX;
  localparam int unsigned CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(W2);
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FW + 1);

  // pin synchronizer: {mosi, cs_n, sclk}
  logic [2:0] sync_q;
  spi_rsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_mosi, spi_cs_n, spi_sclk}), .q(sync_q)
  );

  logic sclk_p, cs_p;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      sclk_p <= sync_q[0];
      cs_p   <= sync_q[1];
    end
  end

  logic sclk_rise, sclk_fall, cs_fall, cs_rise, mosi_q;
  assign sclk_rise = sync_q[0] & ~sclk_p;
  assign sclk_fall = ~sync_q[0] & sclk_p;
  assign cs_fall   = ~sync_q[1] & cs_p;
  assign cs_rise   = sync_q[1] & ~cs_p;
  assign mosi_q    = sync_q[2];

  // frame state
  logic             in_frame, dead, crc_mode;
  logic [CNT_W-1:0] bit_cnt;
  logic [FW-1:0]    rx_sh;
  logic [W2-1:0]    resp_q;
  logic             resp_err;

  // received fields, positioned by frame length
  byte_t cmd_b, data_b, rx_crc, crc_val;
  assign cmd_b  = crc_mode ? rx_sh[FW-1 -: BYTE_W] : rx_sh[W2-1 -: BYTE_W];
  assign data_b = crc_mode ? rx_sh[W2-1 -: BYTE_W] : rx_sh[BYTE_W-1:0];
  assign rx_crc = rx_sh[BYTE_W-1:0];

  spi_rsp_crc #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(cs_fall),
    .step(in_frame && sclk_rise && (bit_cnt < LEN_S)),
    .din(mosi_q), .crc(crc_val)
  );

  logic frame_done, crc_ok, is_wr;
  assign frame_done = cs_rise && in_frame && !dead &&
                      (bit_cnt == (crc_mode ? LEN_L : LEN_S));
  assign crc_ok     = !crc_mode || (rx_crc == crc_val);
  assign is_wr      = cmd_b[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      dead      <= 1'b0;
      crc_mode  <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      resp_q    <= '0;
      resp_err  <= 1'b0;
      reg_wr_en <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      if (cs_fall) begin
        in_frame <= 1'b1;
        dead     <= !clk_ready;
        crc_mode <= crc_en;
        bit_cnt  <= '0;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
      end else if (in_frame && sclk_rise) begin
        rx_sh <= {rx_sh[FW-2:0], mosi_q};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (frame_done) begin
        if (crc_ok) begin
          resp_q    <= {cmd_b, is_wr ? data_b : reg_rdata};
          resp_err  <= 1'b0;
          reg_wr_en <= is_wr;
        end else begin
          resp_err  <= 1'b1;
        end
      end
    end
  end

  assign reg_addr  = cmd_b[ADDR_W-1:0];
  assign reg_wdata = data_b;

  // reply loaded at frame start
  logic [FW-1:0] tx_val;
  always_comb begin
    if (resp_err)    tx_val = {{W2{1'b1}}, ERR_TAIL};
    else if (crc_en) tx_val = {resp_q, crc_word(resp_q, CRC_POLY)};
    else             tx_val = {resp_q, {BYTE_W{1'b0}}};
  end

  logic tx_msb;
  spi_rsp_txsh #(.W(FW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cs_fall), .load_val(tx_val),
    .shift(in_frame && sclk_fall), .msb(tx_msb)
  );

  assign spi_miso = in_frame & (dead | tx_msb);
endmodule

// File: rtl/spi_rsp_checker.sv
module spi_rsp_checker
  import spi_rsp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic            frame_done,
  input logic            resp_err,
  input logic            dead,
  input logic            in_frame,
  input logic [2*BYTE_W-1:0] resp_q
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r3_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(frame_done));

  a_r5_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !resp_err);

  a_r6_dead_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> !reg_wr_en);

  a_r4_resp_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> $stable(resp_q));
endmodule

bind spi_reg_responder spi_rsp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .frame_done(frame_done),
  .resp_err(resp_err), .dead(dead), .in_frame(in_frame), .resp_q(resp_q)
);

// File: tb/test_spi_reg_responder.sv
module test_spi_reg_responder;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic crc_en = 1'b0, clk_ready = 1'b1;
  logic spi_miso, reg_wr_en;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  spi_reg_responder i_spi_reg_responder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .crc_en(crc_en),
    .clk_ready(clk_ready), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata)
  );

  // register file seen by the block
  logic [7:0] mem [128];
  int wr_seen = 0;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr_en) begin
    mem[reg_addr] <= reg_wdata;
    wr_seen <= wr_seen + 1;
  end

  // reference model state
  logic [7:0]  exp_mem [128];
  logic [15:0] exp_resp = '0;
  bit          exp_err = 0;
  int          exp_writes = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [7:0] ref_crc(logic [15:0] w);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic top = c[7];
      c = c << 1;
      if (top != w[i]) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1,
                           input bit use_crc, input bit bad, input bit not_ready,
                           input int nbits, input string req);
    logic [23:0] word, expw, got;
    logic [7:0]  cb, rdv;
    bit full;
    cb = ref_crc({b0, b1}) ^ (bad ? 8'h01 : 8'h00);
    word = use_crc ? {b0, b1, cb} : {b0, b1, 8'h00};
    if (not_ready)    expw = 24'hFFFFFF;
    else if (exp_err) expw = 24'hFFFFAA;
    else              expw = {exp_resp, use_crc ? ref_crc(exp_resp) : 8'h00};
    crc_en = use_crc;
    clk_ready = !not_ready;
    got = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = word[23-i];
      repeat (HALF) @(negedge clk);
      got = {got[22:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
    clk_ready = 1'b1;
    expw = expw >> (24 - nbits);
    check(got == expw, {req, " miso"}, got, expw);
    full = (nbits == (use_crc ? 24 : 16));
    if (!not_ready && full) begin
      if (use_crc && bad) exp_err = 1;
      else begin
        exp_err = 0;
        rdv = b0[7] ? b1 : exp_mem[b0[6:0]];
        exp_resp = {b0, rdv};
        if (b0[7]) begin
          exp_mem[b0[6:0]] = b1;
          exp_writes++;
        end
      end
    end
    check(wr_seen == exp_writes, {req, " wr count"}, 24'(wr_seen), 24'(exp_writes));
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9: idle state
    check(spi_miso == 1'b0, "R9 idle miso", 24'(spi_miso), 24'h0);
    check(reg_wr_en == 1'b0, "R9 idle strobe", 24'(reg_wr_en), 24'h0);
    // R9/R1/R3: first write answers with the zero reply
    run_frame(8'h85, 8'h3C, 0, 0, 0, 16, "R9 R1 R3 first write");
    // R4: read returns prior write echo
    run_frame(8'h05, 8'hEE, 0, 0, 0, 16, "R4 R8 read");
    // R2: CRC mode write with good check
    run_frame(8'h91, 8'hA7, 1, 0, 0, 24, "R2 crc write");
    // R5: bad check byte
    run_frame(8'h92, 8'h11, 1, 1, 0, 24, "R5 bad crc");
    run_frame(8'h12, 8'h00, 1, 0, 0, 24, "R5 error pattern");
    run_frame(8'h12, 8'h00, 1, 0, 0, 24, "R5 no write");
    // R6: clock not ready
    run_frame(8'h93, 8'h77, 1, 0, 1, 24, "R6 not ready");
    run_frame(8'h13, 8'h00, 0, 0, 0, 16, "R6 reply kept");
    run_frame(8'h13, 8'h00, 0, 0, 0, 16, "R6 no write");
    // R7: wrong lengths
    run_frame(8'h94, 8'h66, 0, 0, 0, 10, "R7 short");
    run_frame(8'h95, 8'h66, 0, 0, 0, 24, "R7 long");
    run_frame(8'h14, 8'h00, 1, 0, 0, 16, "R7 crc short");
    run_frame(8'h14, 8'h00, 0, 0, 0, 16, "R7 no write");
    run_frame(8'h15, 8'h00, 0, 0, 0, 16, "R7 no write long");
    // mixed random traffic
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a, d;
      bit uc, bd, nr;
      int nb;
      a  = {1'($urandom % 2), 3'b000, 4'($urandom % 16)};
      d  = 8'($urandom);
      uc = bit'($urandom % 2);
      bd = uc && ($urandom % 6 == 0);
      nr = ($urandom % 8 == 0);
      nb = ($urandom % 8 == 0) ? (uc ? 16 : 24) : (uc ? 24 : 16);
      run_frame(a, d, uc, bd, nr, nb, "R1 R2 R4 R5 R6 R7 R8 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule